// File: doc/BRIEF.md
# Two-Channel DMA Feed Controller

This block moves 32-bit words between system memory and a block-cipher engine. A receive channel reads words from memory, starting at a programmed address, and feeds them to the engine input stream. A transmit channel takes words from the engine output stream and writes them to memory. Each direction passes through its own FIFO. Both channels share one request/grant memory port. Software controls the block through a small register window. Writing a channel's length register starts that channel at once, using the start address already held. A channel raises an interrupt event when it finishes.

Interrupt enables have no read-modify-write path. One register sets enables and another clears them. Software acknowledges completed events by writing them back to the pending register. A FIFO status register gives a full and an empty flag for each channel. A FIFO control register selects the hash input source and the alternate cipher path, and drives both choices out of the block. In this project the cipher engine is a pass-through: the engine input stream loops back to the engine output stream.

Top module: `feed_ctrl`

## Requirements
- R1: After reset, every register reads 0, the FIFO status (0x10) reads 0x55, `irq_o` is low and no memory request is made.
- R2: Writing a length of N bytes starts the channel. N is a multiple of 16, and bits 3:0 of the written value are ignored. The receive channel (start 0x20, length 0x24, control 0x28) reads exactly N/4 words. The transmit channel (0x30, 0x34, 0x38) writes exactly N/4 words. Addresses start at the word-aligned start address and go up by 4. A request holds its address until it is granted.
- R3: Bit 1 of a channel's control register reverses the byte order of each word on that channel. The receive channel swaps as data arrives from memory; the transmit channel swaps as data leaves for memory.
- R4: Status register 0x00 sets bit 3 when the receive channel moves its last word and bit 2 when the transmit channel does. Bits 1:0 read 0.
- R5: A 1 written to a bit of 0x04 sets that enable, and a 1 written to 0x08 clears it. Zeros change nothing. Both addresses read back the enable mask. `irq_o` is high exactly while some status bit has its enable set.
- R6: Pending register 0x0C reads status AND enable. Writing it clears the status bits written as 1.
- R7: A length whose bits above bit 3 are all zero starts nothing: no memory request is made and no status bit is set.
- R8: A length write while the channel is busy is ignored. The held length and the transfer in progress are unchanged.
- R9: FIFO status 0x10 has bit 7 for receive full, bit 6 for receive empty, bit 5 for transmit full and bit 4 for transmit empty. Bits 3:0 read 0101 for the two absent channels. The receive channel stalls while its FIFO is full.
- R10: FIFO control 0x14 bits 1:0 drive `hash_sel_o` (0 independent, 1 cipher input, 2 cipher output). Bit 2 drives `alt_path_o`. All three bits read back.
- R11: Writing 1 to bit 0 of a channel's control register empties that channel's FIFO. The bit reads back as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_en_i | input | 1 | Register access strobe |
| reg_we_i | input | 1 | Register write when high |
| reg_addr_i | input | 8 | Register byte offset |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data, combinational from address |
| irq_o | output | 1 | Interrupt request |
| mem_req_o | output | 1 | Memory request |
| mem_we_o | output | 1 | Memory write (transmit) when high |
| mem_addr_o | output | ADDR_W | Memory byte address |
| mem_wdata_o | output | 32 | Memory write data |
| mem_gnt_i | input | 1 | Request accepted this cycle |
| mem_rvalid_i | input | 1 | Read data valid |
| mem_rdata_i | input | 32 | Read data |
| eng_in_valid_o | output | 1 | Word available to the engine |
| eng_in_data_o | output | 32 | Word to the engine |
| eng_in_ready_i | input | 1 | Engine accepts the word |
| eng_out_valid_i | input | 1 | Engine result available |
| eng_out_data_i | input | 32 | Engine result word |
| eng_out_ready_o | output | 1 | Transmit FIFO can take a word |
| hash_sel_o | output | 2 | Hash input source select |
| alt_path_o | output | 1 | Alternate cipher path select |

## Verification
The bench stops the engine loopback and fills the receive FIFO past its depth. A design that kept reading would overrun the FIFO, and a later flush would leave stale words behind, so the full, empty and flushed FIFO status values expose it. The bench writes the length register a second time during a transfer. A design that restarted would read the wrong number of words or report a changed length. Lengths of 0 and 8 bytes must start nothing; a design that counted bytes instead of 16-byte units would issue requests. Each combination of receive and transmit swap is run: the bytes come out reversed only when exactly one swap is on, and a design that applied swap at the wrong end would leave the words in the wrong order. A completion whose enable is clear must stay off `irq_o` and out of the pending register.

// File: rtl/feed_pkg.sv
package feed_pkg;
  localparam logic [7:0] OFF_STAT     = 8'h00;
  localparam logic [7:0] OFF_IEN_SET  = 8'h04;
  localparam logic [7:0] OFF_IEN_CLR  = 8'h08;
  localparam logic [7:0] OFF_PEND     = 8'h0C;
  localparam logic [7:0] OFF_FSTAT    = 8'h10;
  localparam logic [7:0] OFF_FCTL     = 8'h14;
  localparam logic [7:0] OFF_CH_BASE  = 8'h20;
  localparam logic [7:0] OFF_CH_STEP  = 8'h10;
  localparam logic [7:0] OFF_START    = 8'h00;
  localparam logic [7:0] OFF_LEN      = 8'h04;
  localparam logic [7:0] OFF_CTRL     = 8'h08;
  localparam int         NUM_IRQ      = 4;

  function automatic logic [7:0] chan_reg(input int c, input logic [7:0] off);
    return OFF_CH_BASE + 8'(c) * OFF_CH_STEP + off;
  endfunction

  function automatic logic [31:0] swap_if(input logic [31:0] w, input logic en);
    return en ? {w[7:0], w[15:8], w[23:16], w[31:24]} : w;
  endfunction
endpackage

// File: rtl/feed_fifo.sv
module feed_fifo #(
  parameter int W     = 32,
  parameter int DEPTH = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         flush_i,
  input  logic         push_i,
  input  logic [W-1:0] wdata_i,
  input  logic         pop_i,
  output logic [W-1:0] rdata_o,
  output logic         full_o,
  output logic         empty_o
);
  localparam int AW = $clog2(DEPTH);

  logic [W-1:0] mem_q [DEPTH];
  logic [AW-1:0] wp_q, rp_q;
  logic [AW:0]   cnt_q;
  logic do_push, do_pop;

  assign full_o  = (cnt_q == (AW+1)'(DEPTH));
  assign empty_o = (cnt_q == '0);
  assign do_push = push_i && !full_o;
  assign do_pop  = pop_i && !empty_o;
  assign rdata_o = mem_q[rp_q];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else if (flush_i) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (do_push) wp_q <= wp_q + 1'b1;
      if (do_pop)  rp_q <= rp_q + 1'b1;
      cnt_q <= cnt_q + (AW+1)'(do_push) - (AW+1)'(do_pop);
    end
  end

  always_ff @(posedge clk_i) begin
    if (do_push && !flush_i) mem_q[wp_q] <= wdata_i;
  end
endmodule

// File: rtl/feed_chan.sv
module feed_chan #(
  parameter bit IS_RX  = 1'b1,
  parameter int ADDR_W = 32,
  parameter int CW     = 14
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] base_i,
  input  logic [CW-1:0]     words_i,
  input  logic              room_i,
  input  logic              gnt_i,
  input  logic              ack_i,
  output logic              req_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic              busy_o,
  output logic              done_o
);
  logic [ADDR_W-1:0] addr_q;
  logic [CW-1:0]     issue_q, left_q;
  logic              pend;

  // receive side keeps one read in flight so a returning word always fits
  if (IS_RX) begin : g_rx
    logic pend_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)             pend_q <= 1'b0;
      else if (req_o && gnt_i) pend_q <= 1'b1;
      else if (ack_i)          pend_q <= 1'b0;
    end
    assign pend = pend_q;
  end else begin : g_tx
    assign pend = 1'b0;
  end

  assign req_o  = (issue_q != '0) && room_i && !pend;
  assign addr_o = addr_q;
  assign busy_o = (left_q != '0);
  assign done_o = ack_i && (left_q == CW'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q  <= '0;
      issue_q <= '0;
      left_q  <= '0;
    end else if (start_i) begin
      addr_q  <= base_i;
      issue_q <= words_i;
      left_q  <= words_i;
    end else begin
      if (req_o && gnt_i) begin
        addr_q  <= addr_q + ADDR_W'(4);
        issue_q <= issue_q - 1'b1;
      end
      if (ack_i && busy_o) left_q <= left_q - 1'b1;
    end
  end
endmodule

// File: rtl/feed_irq.sv
module feed_irq #(
  parameter int N = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         set_we_i,
  input  logic         clr_we_i,
  input  logic         ack_we_i,
  input  logic [N-1:0] bits_i,
  input  logic [N-1:0] ev_i,
  output logic [N-1:0] stat_o,
  output logic [N-1:0] en_o,
  output logic         irq_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stat_o <= '0;
      en_o   <= '0;
    end else begin
      // a new event wins over an acknowledge in the same cycle
      stat_o <= (stat_o & ~(ack_we_i ? bits_i : '0)) | ev_i;
      if (set_we_i)      en_o <= en_o | bits_i;
      else if (clr_we_i) en_o <= en_o & ~bits_i;
    end
  end

  assign irq_o = |(stat_o & en_o);
endmodule

// File: rtl/feed_ctrl.sv
module feed_ctrl
  import feed_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int LEN_W      = 16,
  parameter int FIFO_DEPTH = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_en_i,
  input  logic              reg_we_i,
  input  logic [7:0]        reg_addr_i,
  input  logic [31:0]       reg_wdata_i,
  output logic [31:0]       reg_rdata_o,
  output logic              irq_o,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [31:0]       mem_wdata_o,
  input  logic              mem_gnt_i,
  input  logic              mem_rvalid_i,
  input  logic [31:0]       mem_rdata_i,
  output logic              eng_in_valid_o,
  output logic [31:0]       eng_in_data_o,
  input  logic              eng_in_ready_i,
  input  logic              eng_out_valid_i,
  input  logic [31:0]       eng_out_data_i,
  output logic              eng_out_ready_o,
  output logic [1:0]        hash_sel_o,
  output logic              alt_path_o
);
  localparam int CW  = LEN_W - 2;
  localparam int NCH = 2;  // 0 receive, 1 transmit

  logic wr;
  logic [NCH-1:0][ADDR_W-1:0] start_q, caddr;
  logic [NCH-1:0][LEN_W-1:0]  len_q;
  logic [NCH-1:0][CW-1:0]     words;
  logic [NCH-1:0] swap_q, busy, done, req, gnt, ack, room, flush, len_hit, go;
  logic [2:0] fctl_q;
  logic [NUM_IRQ-1:0] stat, ien;
  logic rx_full, rx_empty, tx_full, tx_empty;
  logic [31:0] tx_head;
  logic sel_tx, locked_q, owner_q;

  assign wr = reg_en_i && reg_we_i;

  always_comb begin
    for (int c = 0; c < NCH; c++) begin
      len_hit[c] = wr && (reg_addr_i == chan_reg(c, OFF_LEN));
      words[c]   = {reg_wdata_i[LEN_W-1:4], 2'b00};
      go[c]      = len_hit[c] && !busy[c] && (words[c] != '0);
      flush[c]   = wr && (reg_addr_i == chan_reg(c, OFF_CTRL)) && reg_wdata_i[0];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      start_q <= '0;
      len_q   <= '0;
      swap_q  <= '0;
      fctl_q  <= '0;
    end else if (wr) begin
      for (int c = 0; c < NCH; c++) begin
        if (reg_addr_i == chan_reg(c, OFF_START)) start_q[c] <= reg_wdata_i[ADDR_W-1:0];
        if (len_hit[c] && !busy[c])               len_q[c]   <= reg_wdata_i[LEN_W-1:0];
        if (reg_addr_i == chan_reg(c, OFF_CTRL))  swap_q[c]  <= reg_wdata_i[1];
      end
      if (reg_addr_i == OFF_FCTL) fctl_q <= reg_wdata_i[2:0];
    end
  end

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    feed_chan #(
      .IS_RX (c == 0),
      .ADDR_W(ADDR_W),
      .CW    (CW)
    ) u_chan (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .start_i(go[c]),
      .base_i ({start_q[c][ADDR_W-1:2], 2'b00}),
      .words_i(words[c]),
      .room_i (room[c]),
      .gnt_i  (gnt[c]),
      .ack_i  (ack[c]),
      .req_o  (req[c]),
      .addr_o (caddr[c]),
      .busy_o (busy[c]),
      .done_o (done[c])
    );
  end

  feed_fifo #(.W(32), .DEPTH(FIFO_DEPTH)) u_rx_fifo (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .flush_i(flush[0]),
    .push_i (mem_rvalid_i),
    .wdata_i(swap_if(mem_rdata_i, swap_q[0])),
    .pop_i  (eng_in_ready_i),
    .rdata_o(eng_in_data_o),
    .full_o (rx_full),
    .empty_o(rx_empty)
  );

  feed_fifo #(.W(32), .DEPTH(FIFO_DEPTH)) u_tx_fifo (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .flush_i(flush[1]),
    .push_i (eng_out_valid_i),
    .wdata_i(eng_out_data_i),
    .pop_i  (gnt[1]),
    .rdata_o(tx_head),
    .full_o (tx_full),
    .empty_o(tx_empty)
  );

  assign eng_in_valid_o  = !rx_empty;
  assign eng_out_ready_o = !tx_full;
  assign room            = {!tx_empty, !rx_full};

  // shared memory port: transmit first, owner held until granted
  assign sel_tx      = locked_q ? owner_q : req[1];
  assign mem_req_o   = sel_tx ? req[1] : req[0];
  assign mem_we_o    = sel_tx;
  assign mem_addr_o  = sel_tx ? caddr[1] : caddr[0];
  assign mem_wdata_o = swap_if(tx_head, swap_q[1]);
  assign gnt[1]      = mem_gnt_i && sel_tx && req[1];
  assign gnt[0]      = mem_gnt_i && !sel_tx && req[0];
  assign ack         = {gnt[1], mem_rvalid_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      locked_q <= 1'b0;
      owner_q  <= 1'b0;
    end else begin
      locked_q <= mem_req_o && !mem_gnt_i;
      owner_q  <= sel_tx;
    end
  end

  feed_irq #(.N(NUM_IRQ)) u_irq (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .set_we_i(wr && reg_addr_i == OFF_IEN_SET),
    .clr_we_i(wr && reg_addr_i == OFF_IEN_CLR),
    .ack_we_i(wr && reg_addr_i == OFF_PEND),
    .bits_i  (reg_wdata_i[NUM_IRQ-1:0]),
    .ev_i    ({done[0], done[1], 2'b00}),
    .stat_o  (stat),
    .en_o    (ien),
    .irq_o   (irq_o)
  );

  assign hash_sel_o = fctl_q[1:0];
  assign alt_path_o = fctl_q[2];

  always_comb begin
    reg_rdata_o = '0;
    unique case (reg_addr_i)
      OFF_STAT:                 reg_rdata_o = 32'(stat);
      OFF_IEN_SET, OFF_IEN_CLR: reg_rdata_o = 32'(ien);
      OFF_PEND:                 reg_rdata_o = 32'(stat & ien);
      OFF_FSTAT:                reg_rdata_o = {24'd0, rx_full, rx_empty, tx_full, tx_empty, 4'b0101};
      OFF_FCTL:                 reg_rdata_o = 32'(fctl_q);
      chan_reg(0, OFF_START):   reg_rdata_o = 32'(start_q[0]);
      chan_reg(0, OFF_LEN):     reg_rdata_o = 32'(len_q[0]);
      chan_reg(0, OFF_CTRL):    reg_rdata_o = {30'd0, swap_q[0], 1'b0};
      chan_reg(1, OFF_START):   reg_rdata_o = 32'(start_q[1]);
      chan_reg(1, OFF_LEN):     reg_rdata_o = 32'(len_q[1]);
      chan_reg(1, OFF_CTRL):    reg_rdata_o = {30'd0, swap_q[1], 1'b0};
      default:                  reg_rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/feed_ctrl_chk.sv
module feed_ctrl_chk #(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              reg_en_i,
  input logic              reg_we_i,
  input logic [7:0]        reg_addr_i,
  input logic [31:0]       reg_wdata_i,
  input logic              mem_req_o,
  input logic              mem_we_o,
  input logic              mem_gnt_i,
  input logic [ADDR_W-1:0] mem_addr_o,
  input logic              rx_busy,
  input logic              rx_done,
  input logic [LEN_W-1:0]  rx_len,
  input logic [3:0]        stat,
  input logic              rx_full,
  input logic              rx_empty
);
  logic rx_len_wr;
  assign rx_len_wr = reg_en_i && reg_we_i && (reg_addr_i == 8'h24);

  AST_REQ_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_gnt_i |=> mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o)); // R2

  AST_ADDR_ALIGN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> mem_addr_o[1:0] == 2'b00); // R2

  AST_DONE_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_done |=> stat[3]); // R4

  AST_ZERO_LEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_len_wr && !rx_busy && reg_wdata_i[LEN_W-1:4] == '0 |=> !rx_busy); // R7

  AST_BUSY_LEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_len_wr && rx_busy |=> $stable(rx_len) && rx_busy); // R8

  AST_FIFO_FLAGS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rx_full && rx_empty)); // R9
endmodule

bind feed_ctrl feed_ctrl_chk #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .reg_en_i   (reg_en_i),
  .reg_we_i   (reg_we_i),
  .reg_addr_i (reg_addr_i),
  .reg_wdata_i(reg_wdata_i),
  .mem_req_o  (mem_req_o),
  .mem_we_o   (mem_we_o),
  .mem_gnt_i  (mem_gnt_i),
  .mem_addr_o (mem_addr_o),
  .rx_busy    (busy[0]),
  .rx_done    (done[0]),
  .rx_len     (len_q[0]),
  .stat       (stat),
  .rx_full    (rx_full),
  .rx_empty   (rx_empty)
);

// File: tb/feed_ctrl_test.sv
module feed_ctrl_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;  // 50 MHz

  logic reg_en = 0, reg_we = 0;
  logic [7:0] reg_addr = 0;
  logic [31:0] reg_wdata = 0, reg_rdata;
  logic irq, mem_req, mem_we, mem_gnt, mem_rvalid;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic in_valid, in_ready, out_valid, out_ready;
  logic [31:0] in_data;
  logic [1:0] hash_sel;
  logic alt_path;
  logic loop_en = 1'b1;

  assign in_ready  = loop_en && out_ready;
  assign out_valid = loop_en && in_valid;

  feed_ctrl uut (
    .clk_i(clk), .rst_ni(rst_n),
    .reg_en_i(reg_en), .reg_we_i(reg_we), .reg_addr_i(reg_addr),
    .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata), .irq_o(irq),
    .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr),
    .mem_wdata_o(mem_wdata), .mem_gnt_i(mem_gnt), .mem_rvalid_i(mem_rvalid),
    .mem_rdata_i(mem_rdata),
    .eng_in_valid_o(in_valid), .eng_in_data_o(in_data), .eng_in_ready_i(in_ready),
    .eng_out_valid_i(out_valid), .eng_out_data_i(in_data), .eng_out_ready_o(out_ready),
    .hash_sel_o(hash_sel), .alt_path_o(alt_path)
  );

  function automatic logic [31:0] pat(input logic [7:0] i);
    return {i, ~i, i + 8'h11, 8'h3C};
  endfunction
  function automatic logic [31:0] bswap(input logic [31:0] w);
    return {w[7:0], w[15:8], w[23:16], w[31:24]};
  endfunction

  // memory model: 256 words, pseudo-random grant, read data one cycle after grant
  logic [31:0] mem [0:255];
  logic [7:0] lfsr;
  int rd_cnt;
  assign mem_gnt = lfsr[0] | lfsr[3];
  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 256; i++) mem[i] <= pat(8'(i));
      lfsr <= 8'h5A;
      mem_rvalid <= 1'b0;
      mem_rdata <= '0;
      rd_cnt <= 0;
    end else begin
      lfsr <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      mem_rvalid <= 1'b0;
      if (mem_req && mem_gnt) begin
        if (mem_we) mem[mem_addr[9:2]] <= mem_wdata;
        else begin
          mem_rvalid <= 1'b1;
          mem_rdata <= mem[mem_addr[9:2]];
          rd_cnt <= rd_cnt + 1;
        end
      end
    end
  end

  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_en = 1; reg_we = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_en = 0; reg_we = 0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic wait_stat(input logic [3:0] m);
    logic [31:0] d;
    for (int k = 0; k < 3000; k++) begin
      rd(8'h00, d);
      if ((d[3:0] & m) == m) break;
    end
  endtask

  // {src word, dst word, length bytes, rx swap, tx swap}
  localparam logic [39:0] VEC [5] = '{
    {8'h00, 8'h80, 16'd16, 8'b00},
    {8'h10, 8'h90, 16'd64, 8'b10},
    {8'h20, 8'hA0, 16'd32, 8'b01},
    {8'h30, 8'hB0, 16'd48, 8'b11},
    {8'h05, 8'hC0, 16'd16, 8'b00}
  };

  initial begin
    logic [31:0] d;
    int base;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd(8'h00, d); chk("R1 status", d, 0);
    rd(8'h04, d); chk("R1 enable", d, 0);
    rd(8'h0C, d); chk("R1 pending", d, 0);
    rd(8'h10, d); chk("R1 fifo status", d, 32'h55);
    rd(8'h14, d); chk("R1 fifo ctrl", d, 0);
    rd(8'h24, d); chk("R1 rx length", d, 0);
    rd(8'h38, d); chk("R1 tx ctrl", d, 0);
    chk("R1 irq", irq, 0);
    chk("R1 no request", mem_req, 0);

    // R10 fifo control
    wr(8'h14, 32'h6);
    chk("R10 hash sel", hash_sel, 2); chk("R10 alt path", alt_path, 1);
    rd(8'h14, d); chk("R10 readback", d, 6);
    wr(8'h14, 32'h1);
    chk("R10 hash sel input", {alt_path, hash_sel}, 3'b001);

    // R5 enable set/clear
    wr(8'h04, 32'h8); rd(8'h04, d); chk("R5 set", d, 8);
    wr(8'h04, 32'h0); rd(8'h04, d); chk("R5 set zero", d, 8);
    wr(8'h08, 32'h4); rd(8'h08, d); chk("R5 clr unset bit", d, 8);
    wr(8'h04, 32'h4); rd(8'h04, d); chk("R5 set second", d, 12);
    wr(8'h08, 32'h8); rd(8'h04, d); chk("R5 clr", d, 4);

    // R9/R11/R6: receive only, engine stalled
    loop_en = 0;
    base = rd_cnt;
    wr(8'h20, 32'h0); wr(8'h24, 32'd16);
    wait_stat(4'h8);
    rd(8'h00, d); chk("R4 rx done", d, 8);
    chk("R2 rx read count", rd_cnt - base, 4);
    rd(8'h10, d); chk("R9 rx holding", d, 32'h15);
    chk("R5 masked irq", irq, 0);
    rd(8'h0C, d); chk("R6 pending masked", d, 0);
    wr(8'h04, 32'h8); chk("R5 irq on enable", irq, 1);
    rd(8'h0C, d); chk("R6 pending", d, 8);
    wr(8'h28, 32'h1);
    rd(8'h10, d); chk("R11 flushed", d, 32'h55);
    rd(8'h28, d); chk("R11 flush reads 0", d, 0);
    wr(8'h0C, 32'h8);
    rd(8'h00, d); chk("R6 ack clears", d, 0);
    chk("R5 irq after ack", irq, 0);

    // R9 full: 12 words into a depth-8 FIFO
    base = rd_cnt;
    wr(8'h24, 32'd48);
    repeat (200) @(negedge clk);
    rd(8'h10, d); chk("R9 rx full", d, 32'h95);
    rd(8'h00, d); chk("R9 stalled no done", d, 0);
    chk("R9 stalled read count", rd_cnt - base, 8);
    wr(8'h28, 32'h1);
    wait_stat(4'h8);
    chk("R2 full run read count", rd_cnt - base, 12);
    wr(8'h28, 32'h1); wr(8'h0C, 32'hF);
    loop_en = 1;

    // R7 zero and sub-block lengths
    base = rd_cnt;
    wr(8'h24, 32'd0); wr(8'h24, 32'd8);
    repeat (30) @(negedge clk);
    chk("R7 no reads", rd_cnt - base, 0);
    rd(8'h00, d); chk("R7 no status", d, 0);

    // table of transfers (R2 R3 R4)
    wr(8'h04, 32'hC);
    for (int v = 0; v < 5; v++) begin
      logic [7:0] s, t;
      logic [15:0] n;
      logic srx, stx;
      bit ok;
      logic [31:0] e;
      {s, t, n, srx, stx} = {VEC[v][39:8], VEC[v][1:0]};
      wr(8'h28, {30'd0, srx, 1'b0}); wr(8'h38, {30'd0, stx, 1'b0});
      wr(8'h30, {22'd0, t, 2'b00}); wr(8'h34, 32'(n));
      wr(8'h20, {22'd0, s, 2'b00}); wr(8'h24, 32'(n));
      wait_stat(4'hC);
      rd(8'h00, d); chk("R4 both done", d, 12);
      chk("R5 irq", irq, 1);
      rd(8'h0C, d); chk("R6 pending both", d, 12);
      wr(8'h0C, 32'hC);
      chk("R6 irq cleared", irq, 0);
      ok = 1;
      for (int i = 0; i < n / 4; i++) begin
        e = pat(s + 8'(i));
        if (srx ^ stx) e = bswap(e);
        if (mem[t + 8'(i)] !== e) begin
          ok = 0;
          $display("FAIL R3 word %0d actual=%h expected=%h", i, mem[t + 8'(i)], e);
        end
      end
      chk("R3 data words", ok, 1);
      chk("R2 no extra write", mem[t + 8'(n / 4)], pat(t + 8'(n / 4)));
    end
    wr(8'h28, 32'h0); wr(8'h38, 32'h0);

    // R8 length rewrite while busy
    base = rd_cnt;
    wr(8'h30, 32'h380); wr(8'h34, 32'd64);
    wr(8'h20, 32'h100); wr(8'h24, 32'd64);
    wr(8'h24, 32'd16);
    rd(8'h24, d); chk("R8 length held", d, 64);
    wait_stat(4'hC);
    chk("R8 read count", rd_cnt - base, 16);
    chk("R8 last word", mem[8'hEF], pat(8'h4F));

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule